// File: doc/BRIEF.md
# Serial Register Programming Port

This block is a slave serial port. An external controller uses it to read and write a small bank of configuration registers. Every transfer opens with an 8-bit instruction byte. A data phase follows, and its length equals the byte size of the addressed register. The port runs from a fast local clock. It synchronises the serial clock, chip select, IO reset and serial data, then acts on the detected rising and falling serial-clock edges.

Register 0 is the port's own control register. Its bit 0 selects LSB-first order: 1 means LSB first, 0 means MSB first. Its bit 1 selects the wiring mode. With bit 1 at 0 (2-wire), read data leaves on the bidirectional data pin. With bit 1 at 1 (3-wire), that pin is input only and read data leaves on the separate output pin.

Write data collects in a shadow register and is committed only after its last bit. A transfer cut off by chip select or by the IO reset therefore never corrupts a register.

Top module: `spiRegPort`

## Requirements
- R1: Instruction bit 7 is 1 for a read and 0 for a write. Bit 6 has no effect. Bits 5..0 give the register address.
- R2: The data phase is as long as the addressed register: address 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 1 byte, 4 is 4 bytes, and every other address is 1 byte. Bits that follow, with chip select still low, start a new instruction.
- R3: Write bits are taken on rising serial-clock edges. Read bits are driven after falling edges. A read returns the value last fully written to that register.
- R4: Control bit 0 = 1 sends the instruction and the data LSB first. Control bit 0 = 0 sends them MSB first.
- R5: While chip select is high, both output enables are low and both data outputs are 0.
- R6: In a read with control bit 1 = 0, data leaves on sdioOut with sdioOe high and sdoOe low. With control bit 1 = 1, data leaves on sdoOut with sdoOe high and sdioOe low.
- R7: Holding ioReset high ends the current transfer and disables the outputs. The next eight serial clocks form an instruction. Register contents stay unchanged.
- R8: A write to an unimplemented address (5 to 63) changes no register. A read of such an address returns all zeros.
- R9: If chip select rises before the last data bit of a write, the target register keeps its old value.
- R10: A change to the control bits takes effect from the transfer after the one that writes them, even when chip select stays low between the two.
- R11: After reset, all registers read as zero and both outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| csN | input | 1 | Active-low chip select |
| ioReset | input | 1 | Active-high serial-port resynchronisation |
| sdioIn | input | 1 | Serial data input |
| sdioOut | output | 1 | Read data on the bidirectional pin (2-wire mode) |
| sdioOe | output | 1 | Drive enable of the bidirectional pin |
| sdoOut | output | 1 | Read data on the separate output pin (3-wire mode) |
| sdoOe | output | 1 | Drive enable of the separate output pin |

## Verification
The assertions check four things on every cycle:
- chip select high keeps both pins undriven;
- an ioReset held for several cycles silences the outputs;
- the register bank changes only on a commit strobe;
- a commit to an unimplemented address leaves every register as it was.

Only the bench scenarios can show the rest. These are the per-address data lengths, the bit order and its delayed effect, the pin selection in each mode, back-to-back transfers under one chip select, and that aborted writes leave the old value for a later read.

// File: rtl/spiRegPortPkg.sv
package spiRegPortPkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 5;
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int CNT_W    = IDX_W + 1;

  // byte length of each register address; unlisted addresses take one byte
  function automatic int unsigned regBytes(input logic [ADDR_W-1:0] a);
    case (a)
      6'd0:    return 1;
      6'd1:    return 2;
      6'd2:    return 4;
      6'd3:    return 1;
      6'd4:    return 4;
      default: return 1;
    endcase
  endfunction

  typedef struct packed {
    logic              clearShadow;
    logic              loadRead;
    logic              dataBit;
    logic              commit;
    logic              driveOut;
    logic              clearOut;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  bitIdx;
  } strobe_t;
endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic ioResetIn,
  input  logic sdiIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csHigh,
  output logic ioRst,
  output logic sdiBit
);
  logic [STAGES-1:0] sclkQ, csQ, rstQ, sdiQ;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= '0;
      csQ      <= '1;
      rstQ     <= '0;
      sdiQ     <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkQ    <= {sclkQ[STAGES-2:0], sclkIn};
      csQ      <= {csQ[STAGES-2:0], csNIn};
      rstQ     <= {rstQ[STAGES-2:0], ioResetIn};
      sdiQ     <= {sdiQ[STAGES-2:0], sdiIn};
      sclkLast <= sclkQ[STAGES-1];
    end
  end

  assign sclkRise = sclkQ[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkQ[STAGES-1] & sclkLast;
  assign csHigh   = csQ[STAGES-1];
  assign ioRst    = rstQ[STAGES-1];
  assign sdiBit   = sdiQ[STAGES-1];
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiRegPortPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    abort,
  input  logic    sdiBit,
  input  logic    cfgLsb,
  input  logic    cfgThree,
  output strobe_t strb,
  output logic    readOe,
  output logic    threeAct
);
  typedef enum logic {PH_INSTR, PH_DATA} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenBits;
  logic [CNT_W-1:0] lenNxt;
  logic [7:0]       instr;
  logic [7:0]       instrNxt;
  logic [2:0]       iIdx;
  logic [IDX_W-1:0] dataIdx;
  logic             lsbAct;
  logic             instrDone;
  logic             dataLast;

  assign iIdx = lsbAct ? cnt[2:0] : (3'd7 - cnt[2:0]);

  always_comb begin
    instrNxt       = instr;
    instrNxt[iIdx] = sdiBit;
  end

  assign lenNxt    = CNT_W'(regBytes(instrNxt[ADDR_W-1:0]) * 8);
  assign instrDone = sclkRise && (phase == PH_INSTR) && (cnt == CNT_W'(7));
  assign dataLast  = (phase == PH_DATA) && (cnt == lenBits - 1'b1);
  assign dataIdx   = lsbAct ? cnt[IDX_W-1:0] : IDX_W'(lenBits - 1'b1 - cnt);

  always_comb begin
    strb.clearShadow = instrDone && !abort;
    strb.loadRead    = instrDone && instrNxt[7] && !abort;
    strb.dataBit     = sclkRise && (phase == PH_DATA) && !instr[7] && !abort;
    strb.commit      = sclkRise && dataLast && !instr[7] && !abort;
    strb.driveOut    = sclkFall && (phase == PH_DATA) && readOe && !abort;
    strb.clearOut    = abort || (sclkRise && dataLast);
    strb.addr        = instrDone ? instrNxt[ADDR_W-1:0] : instr[ADDR_W-1:0];
    strb.bitIdx      = dataIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_INSTR;
      cnt      <= '0;
      lenBits  <= CNT_W'(8);
      instr    <= '0;
      readOe   <= 1'b0;
      lsbAct   <= 1'b0;
      threeAct <= 1'b0;
    end else if (abort) begin
      phase    <= PH_INSTR;
      cnt      <= '0;
      readOe   <= 1'b0;
      lsbAct   <= cfgLsb;
      threeAct <= cfgThree;
    end else if (sclkRise) begin
      if (phase == PH_INSTR) begin
        instr <= instrNxt;
        if (cnt == CNT_W'(7)) begin
          phase   <= PH_DATA;
          cnt     <= '0;
          readOe  <= instrNxt[7];
          lenBits <= lenNxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (dataLast) begin
        phase  <= PH_INSTR;
        cnt    <= '0;
        readOe <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if ((phase == PH_INSTR) && (cnt == '0)) begin
      // between transfers: pick up the current mode and order
      lsbAct   <= cfgLsb;
      threeAct <= cfgThree;
    end
  end
endmodule

// File: rtl/spiRegBank.sv
module spiRegBank
  import spiRegPortPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    sdiBit,
  output logic    outBit,
  output logic    cfgLsb,
  output logic    cfgThree
);
  logic [NUM_REGS*DATA_W-1:0] regFlat;
  logic [DATA_W-1:0]          rdVal;
  logic [DATA_W-1:0]          shadow;
  logic [DATA_W-1:0]          shadowNxt;

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.addr == ADDR_W'(i)) rdVal = regFlat[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    shadowNxt = shadow;
    if (strb.dataBit) shadowNxt[strb.bitIdx] = sdiBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
      outBit <= 1'b0;
    end else begin
      if (strb.loadRead)         shadow <= rdVal;
      else if (strb.clearShadow) shadow <= '0;
      else                       shadow <= shadowNxt;
      if (strb.clearOut)         outBit <= 1'b0;
      else if (strb.driveOut)    outBit <= shadow[strb.bitIdx];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam int W = regBytes(ADDR_W'(g)) * 8;
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) val <= '0;
      else if (strb.commit && (strb.addr == ADDR_W'(g))) val <= DATA_W'(shadowNxt[W-1:0]);
    end
    assign regFlat[g*DATA_W +: DATA_W] = val;
  end

  assign cfgLsb   = regFlat[0];
  assign cfgThree = regFlat[1];
endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPortPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic ioReset,
  input  logic sdioIn,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdoOut,
  output logic sdoOe
);
  logic    sclkRise, sclkFall, csHigh, ioRst, sdiBit;
  logic    cfgLsb, cfgThree, outBit, readOe, threeAct, oe;
  strobe_t strb;

  spiSync #(.STAGES(2)) syncU (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .ioResetIn(ioReset),
    .sdiIn(sdioIn), .sclkRise(sclkRise), .sclkFall(sclkFall), .csHigh(csHigh),
    .ioRst(ioRst), .sdiBit(sdiBit)
  );

  spiCtrl ctrlU (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .abort(csHigh | ioRst), .sdiBit(sdiBit), .cfgLsb(cfgLsb), .cfgThree(cfgThree),
    .strb(strb), .readOe(readOe), .threeAct(threeAct)
  );

  spiRegBank bankU (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiBit(sdiBit),
    .outBit(outBit), .cfgLsb(cfgLsb), .cfgThree(cfgThree)
  );

  assign oe      = readOe & ~csN;
  assign sdioOe  = oe & ~threeAct;
  assign sdoOe   = oe & threeAct;
  assign sdioOut = sdioOe & outBit;
  assign sdoOut  = sdoOe & outBit;
endmodule

// File: rtl/spiRegPortChk.sv
module spiRegPortChk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic ioReset,
  input logic sdioOe,
  input logic sdoOe
);
  // R5
  csTriState_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sdioOe && !sdoOe));

  // R7
  ioResetQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioReset && $past(ioReset) && $past(ioReset, 2) && $past(ioReset, 3))
      |-> (!sdioOe && !sdoOe));
endmodule

module spiRegBankChk #(
  parameter int NUM_REGS = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       commit,
  input logic [ADDR_W-1:0]          addr,
  input logic [NUM_REGS*DATA_W-1:0] regFlat
);
  // R9
  regOnlyOnCommit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(regFlat));

  // R8
  unimplNoWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commit && (int'(addr) >= NUM_REGS)) |=> $stable(regFlat));
endmodule

bind spiRegPort spiRegPortChk topChk (
  .clk(clk), .rstN(rstN), .csN(csN), .ioReset(ioReset),
  .sdioOe(sdioOe), .sdoOe(sdoOe)
);

bind spiRegBank spiRegBankChk bankChk (
  .clk(clk), .rstN(rstN), .commit(strb.commit), .addr(strb.addr), .regFlat(regFlat)
);

// File: tb/spiRegPort_test.sv
module spiRegPort_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, ioReset = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [31:0] mdl [0:4];
  logic bLsb, bThree, sawRight, sawWrong;

  always #2 clk = ~clk;

  spiRegPort uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .ioReset(ioReset),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  function automatic int expBytes(input int a);
    case (a)
      0: return 1; 1: return 2; 2: return 4; 3: return 1; 4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] lenMask(input int a);
    return (expBytes(a) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (expBytes(a) * 8)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input logic rd, output logic o);
    sclk = 1'b0;
    sdioIn = b;
    waitClk(HALF);
    o = bThree ? sdoOut : sdioOut;
    if (rd) begin
      if (bThree ? sdoOe : sdioOe) sawRight = 1'b1;
      if (bThree ? sdioOe : sdoOe) sawWrong = 1'b1;
    end
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendInstr(input logic rd, input logic b6, input logic [5:0] a);
    logic [7:0] ins;
    logic o;
    bLsb = mdl[0][0];
    bThree = mdl[0][1];
    ins = {rd, b6, a};
    for (int i = 0; i < 8; i++) sendBit(bLsb ? ins[i] : ins[7-i], 1'b0, o);
  endtask

  task automatic sendData(input logic rd, input int nb, input int nBits,
                          input logic [31:0] d, output logic [31:0] q);
    logic o;
    int idx;
    q = '0;
    sawRight = 1'b0;
    sawWrong = 1'b0;
    for (int j = 0; j < nBits; j++) begin
      idx = bLsb ? j : nb * 8 - 1 - j;
      sendBit(d[idx], rd, o);
      if (rd) q[idx] = o;
    end
  endtask

  task automatic endCs();
    sclk = 1'b0;
    waitClk(4);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic xfer(input logic rd, input logic b6, input int a,
                      input logic [31:0] d, output logic [31:0] q);
    int nb;
    nb = expBytes(a);
    csN = 1'b0;
    waitClk(4);
    sendInstr(rd, b6, 6'(a));
    sendData(rd, nb, nb * 8, d, q);
    endCs();
    if (!rd && a < 5) mdl[a] = d & lenMask(a);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChk++;
      nFail++;
      $display("FAIL R3 watchdog got hung exp finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, d;
    int a;
    logic rd;
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    void'($urandom(32'h5EED_0042));
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R11 reset state
    chk("R11 reset oe", {30'd0, sdioOe, sdoOe}, 32'd0);
    xfer(1'b1, 1'b0, 2, 32'd0, q);
    chk("R11 reset reg2", q, 32'd0);
    xfer(1'b1, 1'b0, 4, 32'd0, q);
    chk("R11 reset reg4", q, 32'd0);

    // R3 R2 two-byte and four-byte write then read, MSB first
    xfer(1'b0, 1'b0, 1, 32'h0000_A5C3, q);
    xfer(1'b1, 1'b0, 1, 32'd0, q);
    chk("R3 reg1 readback", q, 32'h0000_A5C3);
    chk("R6 two-wire pin use", {30'd0, sawRight, sawWrong}, 32'd2);
    xfer(1'b0, 1'b0, 2, 32'hDEAD_BEEF, q);
    // R1 bit 6 set on the read has no effect
    xfer(1'b1, 1'b1, 2, 32'd0, q);
    chk("R1 bit6 ignored reg2", q, 32'hDEAD_BEEF);

    // R8 unimplemented address
    xfer(1'b0, 1'b0, 9, 32'h0000_00FF, q);
    xfer(1'b1, 1'b0, 9, 32'd0, q);
    chk("R8 unimpl read zero", q, 32'd0);
    xfer(1'b1, 1'b0, 1, 32'd0, q);
    chk("R8 reg1 untouched", q, 32'h0000_A5C3);

    // R2 back-to-back transfers under one chip select
    csN = 1'b0;
    waitClk(4);
    sendInstr(1'b0, 1'b0, 6'd3);
    sendData(1'b0, 1, 8, 32'h3C, q);
    mdl[3] = 32'h3C;
    sendInstr(1'b1, 1'b0, 6'd3);
    sendData(1'b1, 1, 8, 32'd0, q);
    endCs();
    chk("R2 back-to-back reg3", q, 32'h3C);

    // R9 chip select rising mid write
    csN = 1'b0;
    waitClk(4);
    sendInstr(1'b0, 1'b0, 6'd2);
    sendData(1'b0, 4, 10, 32'h1234_5678, q);
    endCs();
    xfer(1'b1, 1'b0, 2, 32'd0, q);
    chk("R9 aborted write reg2", q, 32'hDEAD_BEEF);

    // R7 ioReset mid write, then a read without toggling chip select
    csN = 1'b0;
    waitClk(4);
    sendInstr(1'b0, 1'b0, 6'd1);
    sendData(1'b0, 2, 5, 32'h0000_FFFF, q);
    ioReset = 1'b1;
    waitClk(6);
    ioReset = 1'b0;
    waitClk(4);
    sendInstr(1'b1, 1'b0, 6'd1);
    sendData(1'b1, 2, 16, 32'd0, q);
    endCs();
    chk("R7 resync reg1", q, 32'h0000_A5C3);

    // R10 R4 switch to LSB first; the next transfer in the same select uses it
    csN = 1'b0;
    waitClk(4);
    sendInstr(1'b0, 1'b0, 6'd0);
    sendData(1'b0, 1, 8, 32'h01, q);
    mdl[0] = 32'h01;
    sendInstr(1'b1, 1'b0, 6'd2);
    sendData(1'b1, 4, 32, 32'd0, q);
    endCs();
    chk("R10 R4 lsb-first read reg2", q, 32'hDEAD_BEEF);
    xfer(1'b0, 1'b0, 1, 32'h0000_1E87, q);
    xfer(1'b1, 1'b0, 1, 32'd0, q);
    chk("R4 lsb-first reg1", q, 32'h0000_1E87);

    // R6 three-wire mode
    xfer(1'b0, 1'b0, 0, 32'h03, q);
    xfer(1'b1, 1'b0, 4, 32'd0, q);
    chk("R6 three-wire reg4", q, 32'd0);
    xfer(1'b1, 1'b0, 3, 32'd0, q);
    chk("R6 three-wire reg3", q, 32'h3C);
    chk("R6 three-wire pin use", {30'd0, sawRight, sawWrong}, 32'd2);

    // R5 chip select high during a read releases the pins at once
    csN = 1'b0;
    waitClk(4);
    sendInstr(1'b1, 1'b0, 6'd2);
    sendData(1'b1, 4, 4, 32'd0, q);
    chk("R6 oe during read", {30'd0, sdioOe, sdoOe}, 32'd1);
    csN = 1'b1;
    #1;
    chk("R5 cs high oe off", {28'd0, sdioOe, sdoOe, sdioOut, sdoOut}, 32'd0);
    sclk = 1'b0;
    waitClk(6);

    // back to MSB-first 2-wire for the random mix
    xfer(1'b0, 1'b0, 0, 32'h00, q);

    // R3 R2 R8 random traffic against the model
    for (int k = 0; k < 24; k++) begin
      a = int'($urandom_range(1, 7));
      rd = 1'($urandom_range(0, 1));
      d = $urandom();
      xfer(rd, 1'($urandom_range(0, 1)), a, d, q);
      if (rd) chk("R3 random read", q, (a < 5) ? mdl[a] : 32'd0);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule